// File: doc/BRIEF.md
# Packet-Aware Streaming FIFO Decoupler

This block sits between a producer and a consumer on a packet stream. Each word carries a start-of-packet and an end-of-packet flag. The block stores these flags with the data in a power-of-two deep buffer, so the two sides can stall independently while the packet framing stays intact. The producer offers a word with `in_valid`, and the word is taken on any clock where `in_ready` is high. The consumer watches `out_dav` and pulses `out_rd` to pull a word. That word appears one clock later, qualified by `out_valid`.

Both sides share one clock. The output framing flags come from the registered read strobe, not from the raw request. A packet that is a single word, and that is read in a single strobe cycle, therefore still shows its start flag. When `out_rd` is held high across several single-word packets, every word is delivered in order and none is skipped.

Top module: `dcp_pkt_fifo`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_dav` is 0, `in_ready` is 1 and `out_valid` is 0.
- R2: Every accepted word leaves the block exactly once, in acceptance order, with its data, start flag and end flag unchanged.
- R3: A word is stored only on a clock where `in_valid` is 1 and `in_ready` is 1. Flag and data values driven while `in_valid` is 0 are ignored, and `out_dav` stays 0 on an empty buffer.
- R4: A read strobe taken while `out_dav` is 1 makes `out_valid` 1 on the next clock. While `out_valid` is 0, `out_sop` and `out_eop` read 0.
- R5: After DEPTH stored words that have not been read, `in_ready` is 0. Words offered in that state are discarded, so draining yields exactly DEPTH words.
- R6: A read strobe while `out_dav` is 0 is ignored: `out_valid` stays 0 on the next clock, and no later word is skipped.
- R7: Single-word packets (start and end flags both 1) written on consecutive clocks, with `out_rd` held high throughout, all come out, each with its start flag set.
- R8: `out_dav` goes high on the clock after the first word is stored into an empty buffer. It falls on the clock after the last stored word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a word this clock |
| in_sop | input | 1 | Offered word starts a packet |
| in_eop | input | 1 | Offered word ends a packet |
| in_data | input | DATA_W | Offered word payload |
| in_ready | output | 1 | Buffer has room; high means an offered word is taken |
| out_dav | output | 1 | At least one stored word can be pulled |
| out_rd | input | 1 | Consumer read strobe |
| out_valid | output | 1 | Output word valid (one clock after an accepted strobe) |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |
| out_data | output | DATA_W | Output word payload |

## Verification
A stored word raises `out_dav` one clock after its write edge. An accepted strobe presents its word on the outputs one clock after the read edge. A write that fills the buffer drops `in_ready` one clock after the filling edge. The bench keeps a queue model that it updates on each rising edge from the inputs it drove at the previous falling edge. It compares every output at the next falling edge, so each result is sampled in the cycle it is due. The explicit checks for discarded writes, ignored reads and back-to-back single-word packets are taken at falling edges after the stimulus has settled.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    typedef struct packed {
        logic sop;
        logic eop;
    } frame_t;

    localparam frame_t FRAME_NONE = '{sop: 1'b0, eop: 1'b0};

    // Framing bits only mean something on a qualified cycle.
    function automatic frame_t frame_gate(input logic qual, input frame_t f);
        frame_t r;
        r.sop = qual & f.sop;
        r.eop = qual & f.eop;
        return r;
    endfunction

    function automatic frame_t frame_make(input logic s, input logic e);
        frame_t r;
        r.sop = s;
        r.eop = e;
        return r;
    endfunction

endpackage

// File: rtl/dcp_ptr.sv
module dcp_ptr #(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inc,
    output logic [AW:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/dcp_store.sv
module dcp_store
    import dcp_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  frame_t        wframe,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output frame_t        rframe,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem_data [N];
    frame_t        mem_frm  [N];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_data[waddr] <= wdata;
            mem_frm[waddr]  <= wframe;
        end
    end

    assign rdata  = mem_data[raddr];
    assign rframe = mem_frm[raddr];
endmodule

// File: rtl/dcp_out.sv
module dcp_out
    import dcp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  frame_t        frame_in,
    input  logic [DW-1:0] data_in,
    output logic          valid,
    output logic          sop,
    output logic          eop,
    output logic [DW-1:0] data
);
    frame_t hold_frm;
    frame_t shown;

    // valid is the read strobe delayed by one clock; framing is gated by it.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            hold_frm <= FRAME_NONE;
            data     <= '0;
        end else begin
            valid <= load;
            if (load) begin
                hold_frm <= frame_in;
                data     <= data_in;
            end
        end
    end

    assign shown = frame_gate(valid, hold_frm);
    assign sop   = shown.sop;
    assign eop   = shown.eop;
endmodule

// File: rtl/dcp_pkt_fifo.sv
module dcp_pkt_fifo
    import dcp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_dav,
    input  logic              out_rd,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);
    localparam int          AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int          PW      = AW + 1;
    localparam logic [AW:0] DEPTH_V = PW'(DEPTH);

    logic [AW:0]       wr_ptr;
    logic [AW:0]       rd_ptr;
    logic [AW:0]       level;
    logic              full;
    logic              empty;
    logic              wr_fire;
    logic              rd_fire;
    frame_t            wr_frm;
    frame_t            rd_frm;
    logic [DATA_W-1:0] rd_data;

    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty   = (wr_ptr == rd_ptr);
    assign level   = wr_ptr - rd_ptr;
    assign in_ready = ~full;
    assign out_dav  = ~empty;
    assign wr_fire  = in_valid & ~full;
    assign rd_fire  = out_rd & ~empty;
    assign wr_frm   = frame_gate(in_valid, frame_make(in_sop, in_eop));

    dcp_ptr #(.AW(AW)) i_wptr (
        .clk (clk),
        .rst (rst),
        .inc (wr_fire),
        .ptr (wr_ptr)
    );

    dcp_ptr #(.AW(AW)) i_rptr (
        .clk (clk),
        .rst (rst),
        .inc (rd_fire),
        .ptr (rd_ptr)
    );

    dcp_store #(.DW(DATA_W), .AW(AW)) i_store (
        .clk    (clk),
        .we     (wr_fire),
        .waddr  (wr_ptr[AW-1:0]),
        .wframe (wr_frm),
        .wdata  (in_data),
        .raddr  (rd_ptr[AW-1:0]),
        .rframe (rd_frm),
        .rdata  (rd_data)
    );

    dcp_out #(.DW(DATA_W)) i_out (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_fire),
        .frame_in (rd_frm),
        .data_in  (rd_data),
        .valid    (out_valid),
        .sop      (out_sop),
        .eop      (out_eop),
        .data     (out_data)
    );

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> (wr_ptr == $past(wr_ptr))); // R5

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_V); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (out_rd && !out_dav) |=> !out_valid); // R6

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (out_rd && out_dav) |=> out_valid); // R4

    AST_MARK_QUAL: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_sop && !out_eop)); // R4

    AST_DAV_RISE: assert property (@(posedge clk) disable iff (rst)
        (!out_dav && in_valid && in_ready) |=> out_dav); // R8

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!out_dav) |-> in_ready); // R3
endmodule

// File: tb/test_dcp_pkt_fifo.sv
module test_dcp_pkt_fifo;
    localparam int DW    = 16;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_dav;
    logic          out_rd = 1'b0;
    logic          out_valid;
    logic          out_sop;
    logic          out_eop;
    logic [DW-1:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;
    int words_out = 0;
    int sops_out  = 0;
    int accepted  = 0;
    int cycles    = 0;

    logic [DW+1:0] mq[$];
    logic [DW+1:0] pend;
    bit            pend_v;

    always #4 clk = ~clk;

    dcp_pkt_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_dcp_pkt_fifo (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_ready(in_ready), .out_dav(out_dav), .out_rd(out_rd),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard model: updated on each rising edge from the settled inputs.
    always @(posedge clk) begin
        bit wf, rf;
        if (rst) begin
            mq.delete();
            pend_v = 1'b0;
        end else begin
            wf = in_valid && (mq.size() < DEPTH);
            rf = out_rd && (mq.size() > 0);
            pend_v = rf;
            if (rf) pend = mq.pop_front();
            if (wf) begin
                mq.push_back({in_sop, in_eop, in_data});
                accepted++;
            end
        end
    end

    // Monitor: compare at falling edges.
    always @(negedge clk) begin
        if (!rst) begin
            chk(out_valid == pend_v, "R4 out_valid latency", out_valid, pend_v);
            if (pend_v && out_valid) begin
                chk({out_sop, out_eop, out_data} == pend, "R2 word/frame",
                    {out_sop, out_eop, out_data}, pend);
                words_out++;
                if (out_sop) sops_out++;
            end
            if (!out_valid)
                chk(!out_sop && !out_eop, "R4 flags when idle", {out_sop, out_eop}, 0);
            chk(out_dav == (mq.size() > 0), "R8 out_dav", out_dav, mq.size() > 0);
            chk(in_ready == (mq.size() < DEPTH), "R5 in_ready", in_ready, mq.size() < DEPTH);
        end
    end

    task automatic step(input bit v, input bit s, input bit e, input logic [DW-1:0] d, input bit rd);
        @(negedge clk);
        in_valid = v;
        in_sop   = s;
        in_eop   = e;
        in_data  = d;
        out_rd   = rd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 60000);
            finish_run();
        end
    end

    initial begin
        int base_w, base_s, plen, ppos, acc0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_dav == 1'b0, "R1 out_dav in reset", out_dav, 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_dav == 1'b0 && in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
            {out_dav, in_ready, out_valid}, 3'b010);

        // R2: three packets of lengths 1, 3, 2 then drain
        step(1, 1, 1, 16'h0101, 0);
        step(1, 1, 0, 16'h0201, 0);
        step(1, 0, 0, 16'h0202, 0);
        step(1, 0, 1, 16'h0203, 0);
        step(1, 1, 0, 16'h0301, 0);
        step(1, 0, 1, 16'h0302, 0);
        base_w = words_out;
        for (int i = 0; i < 8; i++) step(0, 0, 0, '0, 1);
        idle(2);
        chk(words_out - base_w == 6, "R2 packet words drained", words_out - base_w, 6);

        // R3: flags and data toggling with in_valid low
        for (int i = 0; i < 6; i++) step(0, i[0], !i[0], 16'hA5A5 ^ 16'(i), 0);
        @(negedge clk);
        chk(out_dav == 1'b0, "R3 unqualified input stored", out_dav, 0);

        // R6: reads while empty
        for (int i = 0; i < 3; i++) step(0, 0, 0, '0, 1);
        step(0, 0, 0, '0, 0);
        chk(out_valid == 1'b0, "R6 read on empty", out_valid, 0);

        // R5: overfill then drain
        for (int i = 0; i < DEPTH + 3; i++) step(1, 1, 1, 16'h5000 + 16'(i), 0);
        step(0, 0, 0, '0, 0);
        chk(in_ready == 1'b0, "R5 in_ready when full", in_ready, 0);
        base_w = words_out;
        for (int i = 0; i < DEPTH + 4; i++) step(0, 0, 0, '0, 1);
        idle(2);
        chk(words_out - base_w == DEPTH, "R5 words after overfill", words_out - base_w, DEPTH);
        chk(out_dav == 1'b0, "R8 empty after drain", out_dav, 0);

        // R7: back-to-back single-word packets, read strobe held high
        base_s = sops_out;
        for (int i = 0; i < 12; i++) step(1, 1, 1, 16'h7000 + 16'(i), 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, '0, 1);
        idle(2);
        chk(sops_out - base_s == 12, "R7 single-word packets seen", sops_out - base_s, 12);

        // R2/R5/R6 mixed: random rates, packets of 1..4 words
        acc0 = accepted;
        base_w = words_out;
        plen = 1;
        ppos = 0;
        for (int i = 0; i < 3000; i++) begin
            bit v, rd, take;
            int phase;
            phase = (i / 500) % 3;
            v  = (phase == 0) ? ($urandom % 4 != 0) : (phase == 1) ? ($urandom % 4 == 0) : ($urandom % 2 == 0);
            rd = (phase == 0) ? ($urandom % 4 == 0) : (phase == 1) ? ($urandom % 4 != 0) : ($urandom % 2 == 0);
            if (ppos == 0) plen = 1 + int'($urandom % 4);
            step(v, ppos == 0, ppos == plen - 1, 16'(i), rd);
            take = v && (mq.size() < DEPTH);
            if (take) ppos = (ppos == plen - 1) ? 0 : ppos + 1;
        end
        for (int i = 0; i < DEPTH + 4; i++) step(0, 0, 0, '0, 1);
        idle(2);
        chk(words_out - base_w == accepted - acc0, "R2 random words in = out",
            words_out - base_w, accepted - acc0);

        finish_run();
    end
endmodule